// File: doc/BRIEF.md
# Delay-Commutator FFT Butterfly Stage

This block is one stage of a single-stream pipelined FFT with decimation in frequency. Samples arrive one word per accepted clock. Each complex sample is sent as its real word and then its imaginary word. A delay line of `2·D` words, with `D = N >> STAGE`, lines up each sample with the sample `D` positions later in its block. One real adder and one real subtractor form the halved butterfly sum and difference. Sums are sent out at once. Differences go back into the delay line, and on the way out they are rotated by a twiddle factor.

The output stream has the same word format and the same natural sample order as the input, so stages can be chained. The rotation uses one time-shared multiplier pair. It makes one output word per cycle, either the real or the imaginary half of the rotated difference, from the stored complex difference. The whole stage advances only on words with `in_valid` high. Its latency is therefore a fixed number of accepted words, whatever gaps the source leaves. `STAGE` may range from 1 to log2(N)−1.

Top module: `sdc_bfly_stage`

## Requirements
- R1: While `rst` is high, and at the first edge after it falls, `out_valid` and `out_data` are 0. The first `DW = 2·(N >> STAGE)` accepted words after reset (16 with the defaults) produce no output.
- R2: `out_valid` is high after exactly those edges that accept a word with stream index `k ≥ DW`. The word presented then is output word `k − DW`.
- R3: For complex sample `n` with `(n mod 2D) < D`, the output real word is `floor((x[n].re + x[n+D].re)/2)`, and the imaginary word follows the same rule.
- R4: For sample `n` with `(n mod 2D) = D + m`, let `d = (x[n−D] − x[n])/2`, floored per part. The output is `d · (c − j·s)`, where `c = round(16384·cos(2π·e/N))`, `s = round(16384·sin(2π·e/N))` and `e = m·2^(STAGE−1)`. Each part is rounded by adding 8192, shifted right arithmetically by 14, and then truncated to its low 16 bits.
- R5: The word at even stream index is real and the word at odd index is imaginary. Sample `n` of a frame occupies words `2n` and `2n+1`. The output keeps this format and order, and frames follow each other with no gap or marker.
- R6: While `in_valid` is low, no state advances and `out_data` keeps its value.
- R7: A synchronous reset in mid-stream discards all stored samples. The next accepted word is word 0 of a fresh block, and R1 applies again.
- R8: The halving keeps full-scale operands inside 16 bits. For example, the pair (32767, −32768) and (−32768, 32767) gives the sum (−1, −1) and the difference (32767, −32768).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Input word is presented this cycle |
| in_data | input | W | Input word, two's complement, real/imaginary interleaved |
| out_valid | output | 1 | Output word is presented this cycle |
| out_data | output | W | Output word, two's complement, same interleave |

## Verification
In every second-half cycle the add/sub result drives the output and is written back into the delay line, while the oldest first-half word leaves that same line. At every block boundary, the multiplier starts reading stored differences on the same edge that new first-half samples begin to enter. The bench provokes both with back-to-back frames, with random idle gaps, and with a reset in the middle of a block. A behavioural model of the stage predicts every output word, its position in the stream and the edge it appears on, and the bench compares this against the ports on every clock.

// File: rtl/sdc_fft_pkg.sv
package sdc_fft_pkg;

    localparam int     TW_FRAC     = 14;
    localparam longint HALF_PI_Q30 = 64'sd1686629713;

    // sin(pi/2 * num/den) for 0 <= num <= den, returned in Q1.14, rounded
    function automatic int quarter_sine(input int num, input int den);
        longint x;
        longint x2;
        longint term;
        longint acc;
        x    = (HALF_PI_Q30 * longint'(num)) / longint'(den);
        x2   = (x * x) >>> 30;
        term = x;
        acc  = x;
        for (int k = 1; k <= 7; k++) begin
            term = -((term * x2) >>> 30) / longint'((2 * k) * (2 * k + 1));
            acc  = acc + term;
        end
        return int'((acc + (64'sd1 <<< 15)) >>> 16);
    endfunction

    // cos(2*pi*e/n), 0 <= e < n/2
    function automatic int twiddle_re(input int e, input int n);
        int q;
        q = 4 * e;
        if (q <= n) return quarter_sine(n - q, n);
        return -quarter_sine(q - n, n);
    endfunction

    // sin(2*pi*e/n), 0 <= e < n/2
    function automatic int twiddle_im(input int e, input int n);
        int q;
        q = 4 * e;
        if (q <= n) return quarter_sine(q, n);
        return quarter_sine(2 * n - q, n);
    endfunction

endpackage

// File: rtl/sdc_commutator.sv
module sdc_commutator #(
    parameter int N     = 16,
    parameter int STAGE = 1,
    parameter int W     = 16
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          step,
    input  logic [W-1:0]                  in_data,
    input  logic [W-1:0]                  fb_data,
    output logic                          phase_hi,
    output logic                          part_im,
    output logic [$clog2(N>>STAGE)-1:0]   pos,
    output logic [W-1:0]                  tap_now,
    output logic [W-1:0]                  tap_next,
    output logic                          primed
);
    localparam int D   = N >> STAGE;
    localparam int DW  = 2 * D;
    localparam int LDW = $clog2(DW);
    localparam int CW  = LDW + 1;

    typedef struct packed {
        logic [DW-1:0][W-1:0] line;
        logic [CW-1:0]        cnt;
        logic                 primed;
    } comm_state_t;

    comm_state_t st_d, st_q;

    assign phase_hi = st_q.cnt[LDW];
    assign part_im  = st_q.cnt[0];
    assign pos      = st_q.cnt[LDW-1:1];
    assign tap_now  = st_q.line[DW-1];
    assign tap_next = st_q.line[DW-2];
    assign primed   = st_q.primed;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.line[0] = phase_hi ? fb_data : in_data;
            for (int i = 1; i < DW; i++) begin
                st_d.line[i] = st_q.line[i-1];
            end
            st_d.cnt = st_q.cnt + 1'b1;
            if (st_q.cnt == CW'(DW - 1)) begin
                st_d.primed = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/sdc_addsub.sv
module sdc_addsub #(
    parameter int W = 16
) (
    input  logic signed [W-1:0] op_a,
    input  logic signed [W-1:0] op_b,
    output logic signed [W-1:0] half_sum,
    output logic signed [W-1:0] half_diff
);
    logic signed [W:0] wide_sum;
    logic signed [W:0] wide_diff;

    always_comb begin
        wide_sum  = (W+1)'(op_a) + (W+1)'(op_b);
        wide_diff = (W+1)'(op_a) - (W+1)'(op_b);
        half_sum  = W'(wide_sum >>> 1);
        half_diff = W'(wide_diff >>> 1);
    end

endmodule

// File: rtl/sdc_twiddle_mul.sv
module sdc_twiddle_mul
    import sdc_fft_pkg::*;
#(
    parameter int N     = 16,
    parameter int STAGE = 1,
    parameter int W     = 16,
    parameter int TW    = 16
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         step,
    input  logic                         part_im,
    input  logic [$clog2(N>>STAGE)-1:0]  pos,
    input  logic signed [W-1:0]          tap_now,
    input  logic signed [W-1:0]          tap_next,
    output logic signed [W-1:0]          prod
);
    localparam int     D        = N >> STAGE;
    localparam int     PW       = W + TW;
    localparam int     AW       = PW + 1;
    localparam longint HALF_LSB = 64'sd1 <<< (TW_FRAC - 1);

    typedef struct packed {
        logic signed [W-1:0] held;
    } mul_state_t;

    mul_state_t st_d, st_q;

    logic signed [TW-1:0] rom_c [D];
    logic signed [TW-1:0] rom_s [D];

    for (genvar g = 0; g < D; g++) begin : g_rom
        assign rom_c[g] = TW'(twiddle_re(g << (STAGE - 1), N));
        assign rom_s[g] = TW'(twiddle_im(g << (STAGE - 1), N));
    end

    logic signed [TW-1:0] coef_c;
    logic signed [TW-1:0] coef_s;
    logic signed [W-1:0]  op_b;
    logic signed [PW-1:0] p_one;
    logic signed [PW-1:0] p_two;
    logic signed [AW-1:0] acc;

    always_comb begin
        st_d = st_q;
        if (step && !part_im) begin
            st_d.held = tap_now;
        end
        coef_c = rom_c[pos];
        coef_s = rom_s[pos];
        // real half: dr*c + di*s ; imaginary half: di*c - dr*s
        op_b   = part_im ? st_q.held : tap_next;
        p_one  = PW'(tap_now) * PW'(coef_c);
        p_two  = PW'(op_b) * PW'(coef_s);
        acc    = part_im ? (AW'(p_one) - AW'(p_two)) : (AW'(p_one) + AW'(p_two));
        prod   = W'((acc + AW'(HALF_LSB)) >>> TW_FRAC);
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

endmodule

// File: rtl/sdc_bfly_stage.sv
module sdc_bfly_stage #(
    parameter int N     = 16,
    parameter int STAGE = 1,
    parameter int W     = 16,
    parameter int TW    = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data
);
    localparam int D  = N >> STAGE;
    localparam int MW = $clog2(D);

    typedef struct packed {
        logic         out_valid;
        logic [W-1:0] out_data;
    } out_state_t;

    out_state_t st_d, st_q;

    logic          phase_hi;
    logic          part_im;
    logic [MW-1:0] pos;
    logic [W-1:0]  tap_now;
    logic [W-1:0]  tap_next;
    logic          primed;
    logic [W-1:0]  half_sum;
    logic [W-1:0]  half_diff;
    logic [W-1:0]  prod;

    sdc_commutator #(.N(N), .STAGE(STAGE), .W(W)) i_comm (
        .clk      (clk),
        .rst      (rst),
        .step     (in_valid),
        .in_data  (in_data),
        .fb_data  (half_diff),
        .phase_hi (phase_hi),
        .part_im  (part_im),
        .pos      (pos),
        .tap_now  (tap_now),
        .tap_next (tap_next),
        .primed   (primed)
    );

    sdc_addsub #(.W(W)) i_addsub (
        .op_a      (tap_now),
        .op_b      (in_data),
        .half_sum  (half_sum),
        .half_diff (half_diff)
    );

    sdc_twiddle_mul #(.N(N), .STAGE(STAGE), .W(W), .TW(TW)) i_mul (
        .clk      (clk),
        .rst      (rst),
        .step     (in_valid),
        .part_im  (part_im),
        .pos      (pos),
        .tap_now  (tap_now),
        .tap_next (tap_next),
        .prod     (prod)
    );

    always_comb begin
        st_d           = st_q;
        st_d.out_valid = in_valid && primed;
        if (in_valid) begin
            st_d.out_data = phase_hi ? half_sum : prod;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign out_valid = st_q.out_valid;
    assign out_data  = st_q.out_data;

endmodule

// File: rtl/sdc_bfly_stage_chk.sv
module sdc_bfly_stage_chk #(
    parameter int N     = 16,
    parameter int STAGE = 1,
    parameter int W     = 16
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic         out_valid,
    input logic [W-1:0] out_data
);
    localparam int DW = 2 * (N >> STAGE);
    localparam int SW = $clog2(DW + 2);

    logic [SW-1:0] seen_q;

    always_ff @(posedge clk) begin
        if (rst) seen_q <= '0;
        else if (in_valid && seen_q != SW'(DW + 1)) seen_q <= seen_q + 1'b1;
    end

    AST_RST_QUIET: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> !out_valid);                                   // R1
    AST_FILL_QUIET: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> (seen_q == SW'(DW + 1)));                       // R1
    AST_OUT_NEEDS_IN: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid));                               // R2
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> !out_valid);                                    // R2
    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> $stable(out_data));                             // R6

endmodule

bind sdc_bfly_stage sdc_bfly_stage_chk #(.N(N), .STAGE(STAGE), .W(W)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/test_sdc_bfly_stage.sv
module test_sdc_bfly_stage;
    localparam int N     = 16;
    localparam int STAGE = 1;
    localparam int W     = 16;
    localparam int D     = N >> STAGE;
    localparam int DW    = 2 * D;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [W-1:0] in_data = '0;
    logic         out_valid;
    logic [W-1:0] out_data;

    int    checks = 0;
    int    fails = 0;
    int    exp_q[$];
    string tag_q[$];
    int    sent = 0;
    int    cur_idx = 0;
    bit    prev_v = 1'b0;
    bit    prev_rst = 1'b1;
    int    prev_idx = 0;
    int    last_out = 0;

    always #4 clk = ~clk;

    sdc_bfly_stage #(.N(N), .STAGE(STAGE), .W(W)) i_sdc_bfly_stage (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .out_valid (out_valid),
        .out_data  (out_data)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_test();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    function automatic int wrap16(input longint v);
        logic signed [15:0] t;
        t = v[15:0];
        return int'(t);
    endfunction

    function automatic int rnd(input real v);
        if (v >= 0.0) return $rtoi(v + 0.5);
        return -$rtoi(-v + 0.5);
    endfunction

    // monitor: compare every clock, away from the active edge
    always @(negedge clk) begin
        bit exp_v;
        int sv;
        exp_v = prev_v && !prev_rst && (prev_idx >= DW);
        if (prev_rst) begin
            check(out_valid == 1'b0, "R1 out_valid in reset", int'(out_valid), 0);
            check(out_data == '0, "R1 out_data in reset", int'(out_data), 0);
            last_out = 0;
        end else begin
            check(out_valid == exp_v, (prev_idx < DW) ? "R1 fill out_valid" : "R2 out_valid",
                  int'(out_valid), int'(exp_v));
            sv = int'($signed(out_data));
            if (out_valid && exp_v) begin
                if (exp_q.size() > 0) begin
                    string t;
                    int e;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    check(sv == e, t, sv, e);
                end
                last_out = sv;
            end else if (!out_valid) begin
                check(sv == last_out, "R6 out_data hold", sv, last_out);
            end
        end
        prev_v   = in_valid;
        prev_rst = rst;
        prev_idx = cur_idx;
    end

    task automatic idle_cycle();
        @(posedge clk);
        #1;
        in_valid = 1'b0;
        in_data  = W'($urandom);
    endtask

    task automatic put_word(input int v);
        @(posedge clk);
        #1;
        in_valid = 1'b1;
        in_data  = W'(v);
        cur_idx  = sent;
        sent++;
    endtask

    task automatic send_frame(input int kind, input bit gaps, input string ctx, input int limit);
        int xr[N];
        int xi[N];
        int words;
        for (int n = 0; n < N; n++) begin
            case (kind)
                0: begin xr[n] = (n == 0) ? 4000 : 0; xi[n] = (n == 3) ? -2500 : 0; end
                1: begin xr[n] = n * 1000 - 8000; xi[n] = -n * 300; end
                2: begin xr[n] = int'($urandom_range(40000)) - 20000;
                         xi[n] = int'($urandom_range(40000)) - 20000; end
                3: begin
                    xr[n] = ((n / D) % 2 == 0) ? 32767 : -32768;
                    xi[n] = ((n / D) % 2 == 0) ? -32768 : 32767;
                end
                default: begin xr[n] = 0; xi[n] = 0; end
            endcase
        end
        // expected output words (R3 sums, R4 rotated differences)
        for (int n = 0; n < N; n++) begin
            int b;
            b = n % (2 * D);
            if (b < D) begin
                exp_q.push_back((xr[n] + xr[n + D]) >>> 1);
                exp_q.push_back((xi[n] + xi[n + D]) >>> 1);
                tag_q.push_back({"R3 sum re ", ctx});
                tag_q.push_back({"R3 sum im ", ctx});
            end else begin
                int     m;
                int     e;
                longint dr;
                longint di;
                longint c;
                longint s;
                real    ang;
                m   = b - D;
                e   = m << (STAGE - 1);
                dr  = longint'((xr[n - D] - xr[n]) >>> 1);
                di  = longint'((xi[n - D] - xi[n]) >>> 1);
                ang = 2.0 * 3.14159265358979 * real'(e) / real'(N);
                c   = longint'(rnd(16384.0 * $cos(ang)));
                s   = longint'(rnd(16384.0 * $sin(ang)));
                exp_q.push_back(wrap16((dr * c + di * s + 8192) >>> 14));
                exp_q.push_back(wrap16((di * c - dr * s + 8192) >>> 14));
                tag_q.push_back({"R4 diff re ", ctx});
                tag_q.push_back({"R4 diff im ", ctx});
            end
        end
        words = 0;
        for (int n = 0; n < N; n++) begin
            for (int p = 0; p < 2; p++) begin
                if (words < limit) begin
                    if (gaps && ($urandom_range(2) == 0)) begin
                        idle_cycle();
                        if ($urandom_range(1) == 0) idle_cycle();
                    end
                    put_word((p == 0) ? xr[n] : xi[n]);
                    words++;
                end
            end
        end
    endtask

    task automatic do_reset();
        @(posedge clk);
        #1;
        rst      = 1'b1;
        in_valid = 1'b1;
        in_data  = W'(12345);
        repeat (2) @(posedge clk);
        #1;
        rst      = 1'b0;
        in_valid = 1'b0;
        exp_q.delete();
        tag_q.delete();
        sent     = 0;
        cur_idx  = 0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL R2 watchdog: actual=running expected=finished");
        finish_test();
    end

    initial begin
        // R1: reset state, then fill period
        repeat (3) @(posedge clk);
        #1;
        rst = 1'b0;
        idle_cycle();
        // R5: back-to-back frames, several patterns
        send_frame(0, 1'b0, "R5 impulse", 2 * N);
        send_frame(1, 1'b0, "R5 ramp", 2 * N);
        send_frame(2, 1'b0, "R5 random", 2 * N);
        // R6: idle gaps inside the stream
        send_frame(2, 1'b1, "R6 gaps", 2 * N);
        send_frame(1, 1'b1, "R6 gaps", 2 * N);
        // R8: full-scale operands
        send_frame(3, 1'b0, "R8 full scale", 2 * N);
        // R7: reset in the middle of a block
        send_frame(2, 1'b0, "R7 pre-reset", 11);
        do_reset();
        send_frame(2, 1'b0, "R7 after reset", 2 * N);
        send_frame(3, 1'b1, "R7 R8 after reset", 2 * N);
        send_frame(1, 1'b0, "R7 after reset", 2 * N);
        // flush
        send_frame(4, 1'b0, "flush", 2 * N);
        repeat (4) idle_cycle();
        @(negedge clk);
        finish_test();
    end

endmodule